// File: doc/BRIEF.md
# Two-Way Cache Flush Sequencer

This block empties a two-way set-associative second-level cache on command. Software writes 1 to a single flush control bit. The sequencer then walks the tag array in way-major order: every index of way 0 from the lowest upward, then every index of way 1 in the same way. For each entry it reads the tag state. It issues one castout request for each modified 32-byte sector of a valid entry, and then writes the entry back as invalid. When the last entry of way 1 has been invalidated, the control bit drops to 0 on its own. Castouts that were already accepted may still be waiting in the downstream queue at that point.

While the walk runs, the busy output holds off the instruction-side and data-side lookups. Snoops keep their access to the tag port. A snoop takes the port in any cycle in which it asks for it. The sequencer freezes its index, way and sector position until the port is free again. Castouts use a valid/ready handshake. A request is held unchanged until it is accepted, and it is never repeated afterwards.

Top module: `cflush_engine`

## Requirements
- R1: After synchronous reset, `busy`, `cfg_rd_flush`, `co_valid` and `tag_en` are all 0.
- R2: A cycle with `cfg_wr_en`=1 and `cfg_wr_flush`=1 while idle starts a flush. From the next cycle `busy` is 1, and the first tag access is a read of index 0, way 0. A write of 0 while idle starts nothing.
- R3: Tag entries are visited and invalidated in the order way 0 index 0 up to the top index, then way 1 index 0 up to the top index. Each entry is visited exactly once.
- R4: The tag entry layout is {valid (MSB), dirty[SECTORS-1:0], tag (LSBs)}. A valid entry gets one castout for each dirty bit set, in ascending sector order. The castout address is ((tag*NIDX + index)*SECTORS + sector)*32, and `co_way` gives the way. An invalid entry gets no castout, whatever its dirty bits hold.
- R5: While `co_valid`=1 and `co_ready`=0, the next cycle keeps `co_valid`=1 with the same `co_addr` and `co_way`. Each castout is accepted exactly once.
- R6: An entry is invalidated by a tag write of all zeros. The write happens only after all castouts for that entry have been accepted. Clean or invalid entries are written without any castout.
- R7: `busy` and `cfg_rd_flush` are both 1 throughout the flush. `co_valid` and `tag_en` are never 1 unless `busy` is 1.
- R8: In any cycle with `snoop_req`=1, `tag_en` is 0. The walk resumes afterwards without skipping or repeating an entry.
- R9: While a flush runs, writing 0 does not abort it and writing 1 does not restart it.
- R10: After the last entry is invalidated, `busy` and `cfg_rd_flush` return to 0, and every tag entry in both ways holds valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_flush | input | 1 | Value written to the flush bit |
| cfg_rd_flush | output | 1 | Current value of the flush bit |
| tag_en | output | 1 | Tag port access enable |
| tag_we | output | 1 | Tag port write (1) or read (0) |
| tag_way | output | 1 | Way selected on the tag port |
| tag_idx | output | IDX_W | Index selected on the tag port |
| tag_wdata | output | 1+SECTORS+TAG_W | Entry written to the tag array |
| tag_rdata | input | 1+SECTORS+TAG_W | Entry read from the tag array, same cycle |
| co_valid | output | 1 | Castout request valid |
| co_ready | input | 1 | Castout request accepted |
| co_addr | output | TAG_W+IDX_W+$clog2(SECTORS)+5 | Sector-aligned castout byte address |
| co_way | output | 1 | Way of the castout |
| snoop_req | input | 1 | Snoop claims the tag port this cycle |
| busy | output | 1 | Flush in progress; blocks cache lookups |

## Verification
A wrong walk position shows up at the first tag write after the fault. The invalidation order no longer matches, or an entry's invalidation arrives before its castouts are all accepted. A lost or duplicated sector in the pending mask changes the castout list within a few cycles. A request that moves under backpressure is caught in the very next cycle. Any collision with a snoop is seen in the cycle it happens. A flag that clears early or late is visible as a mismatch of `busy` against the end of the last invalidation.

// File: rtl/cflush_pkg.sv
package cflush_pkg;

    localparam int SECTOR_OFS_W = 5;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_READ  = 2'd1,
        FL_CAST  = 2'd2,
        FL_CLEAR = 2'd3
    } flush_state_e;

    function automatic int sec_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cflush_walker.sv
module cflush_walker #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             way,
    output logic             last
);
    localparam logic [IDX_W-1:0] IDX_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            way <= 1'b0;
        end else if (start) begin
            idx <= '0;
            way <= 1'b0;
        end else if (step) begin
            if (idx == IDX_TOP) begin
                idx <= '0;
                way <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign last = way && (idx == IDX_TOP);

    // R3: a step moves exactly one position forward in way-major order
    assert_walk_order_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !start && !last) |=>
            ((idx == $past(idx) + 1'b1) && (way == $past(way))) ||
            ((idx == '0) && way && !$past(way)));

    // R8: with no step and no start the position is frozen
    assert_hold_pos_R8: assert property (@(posedge clk) disable iff (rst)
        (!step && !start) |=> ($stable(idx) && $stable(way)));
endmodule

// File: rtl/cflush_sector.sv
module cflush_sector #(
    parameter int SECTORS = 2,
    parameter int SW      = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [SECTORS-1:0] load_mask,
    input  logic               accept,
    output logic               pend,
    output logic [SW-1:0]      cur_sec
);
    logic [SECTORS-1:0] mask_q;
    logic [SECTORS-1:0] low_bit;

    always_comb begin
        cur_sec = '0;
        low_bit = '0;
        for (int s = SECTORS - 1; s >= 0; s--) begin
            if (mask_q[s]) begin
                cur_sec = SW'(s);
                low_bit = '0;
                low_bit[s] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= load_mask;
        end else if (accept) begin
            mask_q <= mask_q & ~low_bit;
        end
    end

    assign pend = |mask_q;

    // R5: an accepted sector leaves the pending set one bit smaller
    assert_one_per_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !load) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));
endmodule

// File: rtl/cflush_engine.sv
module cflush_engine
    import cflush_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int SECTORS = 2,
    parameter int TAG_W   = 10
) (
    input  logic                                             clk,
    input  logic                                             rst,
    input  logic                                             cfg_wr_en,
    input  logic                                             cfg_wr_flush,
    output logic                                             cfg_rd_flush,
    output logic                                             tag_en,
    output logic                                             tag_we,
    output logic                                             tag_way,
    output logic [IDX_W-1:0]                                 tag_idx,
    output logic [SECTORS+TAG_W:0]                           tag_wdata,
    input  logic [SECTORS+TAG_W:0]                           tag_rdata,
    output logic                                             co_valid,
    input  logic                                             co_ready,
    output logic [TAG_W+IDX_W+$clog2(SECTORS)+SECTOR_OFS_W-1:0] co_addr,
    output logic                                             co_way,
    input  logic                                             snoop_req,
    output logic                                             busy
);
    localparam int NIDX   = 1 << IDX_W;
    localparam int SW     = sec_bits(SECTORS);
    localparam int ADDR_W = TAG_W + IDX_W + $clog2(SECTORS) + SECTOR_OFS_W;
    localparam int ENT_W  = 1 + SECTORS + TAG_W;

    flush_state_e       state;
    logic               flag_q;
    logic [TAG_W-1:0]   cur_tag;
    logic               start, step, last;
    logic [IDX_W-1:0]   w_idx;
    logic               w_way;
    logic               rd_valid;
    logic [SECTORS-1:0] rd_dirty;
    logic [TAG_W-1:0]   rd_tag;
    logic               sec_load, sec_pend, accept;
    logic [SW-1:0]      cur_sec;
    logic               port_free;

    assign rd_valid = tag_rdata[ENT_W-1];
    assign rd_dirty = tag_rdata[TAG_W +: SECTORS];
    assign rd_tag   = tag_rdata[TAG_W-1:0];

    assign port_free = !snoop_req;
    assign start     = (state == FL_IDLE) && cfg_wr_en && cfg_wr_flush;
    assign step      = (state == FL_CLEAR) && port_free && !last;
    assign sec_load  = (state == FL_READ) && port_free;
    assign accept    = co_valid && co_ready;

    cflush_walker #(.IDX_W(IDX_W)) u_walker (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .step  (step),
        .idx   (w_idx),
        .way   (w_way),
        .last  (last)
    );

    cflush_sector #(.SECTORS(SECTORS), .SW(SW)) u_sector (
        .clk       (clk),
        .rst       (rst),
        .load      (sec_load),
        .load_mask (rd_valid ? rd_dirty : '0),
        .accept    (accept),
        .pend      (sec_pend),
        .cur_sec   (cur_sec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FL_IDLE;
            flag_q  <= 1'b0;
            cur_tag <= '0;
        end else begin
            case (state)
                FL_IDLE: begin
                    if (start) begin
                        state  <= FL_READ;
                        flag_q <= 1'b1;
                    end
                end
                FL_READ: begin
                    if (port_free) begin
                        cur_tag <= rd_tag;
                        state   <= FL_CAST;
                    end
                end
                FL_CAST: begin
                    if (!sec_pend) state <= FL_CLEAR;
                end
                FL_CLEAR: begin
                    if (port_free) begin
                        if (last) begin
                            state  <= FL_IDLE;
                            flag_q <= 1'b0;
                        end else begin
                            state <= FL_READ;
                        end
                    end
                end
                default: state <= FL_IDLE;
            endcase
        end
    end

    always_comb begin
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(cur_tag);
        a = a * ADDR_W'(NIDX) + ADDR_W'(w_idx);
        a = a * ADDR_W'(SECTORS) + ADDR_W'(cur_sec);
        co_addr = a << SECTOR_OFS_W;
    end

    assign busy         = (state != FL_IDLE);
    assign cfg_rd_flush = flag_q;
    assign tag_en       = ((state == FL_READ) || (state == FL_CLEAR)) && port_free;
    assign tag_we       = (state == FL_CLEAR) && port_free;
    assign tag_way      = w_way;
    assign tag_idx      = w_idx;
    assign tag_wdata    = '0;
    assign co_valid     = (state == FL_CAST) && sec_pend;
    assign co_way       = w_way;

    // R8: the engine never drives the tag port while a snoop owns it
    assert_snoop_yield_R8: assert property (@(posedge clk) disable iff (rst)
        snoop_req |-> !tag_en);

    // R5: a stalled castout stays put
    assert_co_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (co_valid && !co_ready) |=> (co_valid && $stable(co_addr) && $stable(co_way)));

    // R6: invalidation only after the pending sectors are drained
    assert_inv_after_cast_R6: assert property (@(posedge clk) disable iff (rst)
        tag_we |-> !sec_pend);

    // R7: port activity only while busy, and the flag follows busy
    assert_busy_cover_R7: assert property (@(posedge clk) disable iff (rst)
        (co_valid || tag_en) |-> (busy && cfg_rd_flush));

    // R2: a flush begins at way 0, index 0
    assert_start_pos_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (w_idx == '0 && !w_way));

    // R10: the flag drops only together with the end of the walk
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_rd_flush) |-> ($past(last) && !busy));
endmodule

// File: tb/test_cflush_engine.sv
module test_cflush_engine;
    localparam int IDX_W   = 3;
    localparam int SECTORS = 2;
    localparam int TAG_W   = 10;
    localparam int NIDX    = 1 << IDX_W;
    localparam int ENT_W   = 1 + SECTORS + TAG_W;
    localparam int ADDR_W  = TAG_W + IDX_W + $clog2(SECTORS) + 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr_en = 1'b0, cfg_wr_flush = 1'b0;
    logic cfg_rd_flush, tag_en, tag_we, tag_way, busy, co_valid, co_way;
    logic [IDX_W-1:0] tag_idx;
    logic [ENT_W-1:0] tag_wdata, tag_rdata;
    logic co_ready = 1'b1, snoop_req = 1'b0;
    logic [ADDR_W-1:0] co_addr;

    always #2 clk = ~clk;

    cflush_engine #(.IDX_W(IDX_W), .SECTORS(SECTORS), .TAG_W(TAG_W)) i_cflush_engine (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_flush(cfg_wr_flush),
        .cfg_rd_flush(cfg_rd_flush), .tag_en(tag_en), .tag_we(tag_we), .tag_way(tag_way),
        .tag_idx(tag_idx), .tag_wdata(tag_wdata), .tag_rdata(tag_rdata),
        .co_valid(co_valid), .co_ready(co_ready), .co_addr(co_addr), .co_way(co_way),
        .snoop_req(snoop_req), .busy(busy)
    );

    logic [ENT_W-1:0] mem [2][NIDX];
    logic [ENT_W-1:0] img [2][NIDX];
    assign tag_rdata = mem[tag_way][tag_idx];
    always @(posedge clk) if (tag_en && tag_we) mem[tag_way][tag_idx] <= tag_wdata;

    int n_tests = 0, n_fail = 0;
    int rdy_mode = 0, snp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        co_ready  = (rdy_mode == 0) ? 1'b1 : lfsr[0] & lfsr[3];
        snoop_req = (snp_mode == 0) ? 1'b0 : (lfsr[5] & lfsr[7]);
    end

    logic [ADDR_W-1:0] log_addr [64];
    logic              log_way  [64];
    int n_log, wr_seq, hold_err, snoop_err, order_err, early_err, data_err, idle_err;
    int ent_cnt [2][NIDX];
    logic held_prev;
    logic [ADDR_W-1:0] prev_addr;
    logic prev_way;

    function automatic int dirty_cnt(input logic [ENT_W-1:0] e);
        int c = 0;
        if (e[ENT_W-1]) for (int s = 0; s < SECTORS; s++) if (e[TAG_W + s]) c++;
        return c;
    endfunction

    task automatic mon_clear();
        n_log = 0; wr_seq = 0; hold_err = 0; snoop_err = 0; order_err = 0;
        early_err = 0; data_err = 0; idle_err = 0; held_prev = 1'b0;
        for (int w = 0; w < 2; w++) for (int i = 0; i < NIDX; i++) ent_cnt[w][i] = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (held_prev && !(co_valid && co_addr == prev_addr && co_way == prev_way)) hold_err++;
            held_prev = co_valid && !co_ready;
            prev_addr = co_addr; prev_way = co_way;
            if ((co_valid || tag_en) && !busy) idle_err++;
            if (snoop_req && tag_en) snoop_err++;
            if (co_valid && co_ready && n_log < 64) begin
                log_addr[n_log] = co_addr; log_way[n_log] = co_way;
                ent_cnt[co_way][(co_addr / (32 * SECTORS)) % NIDX]++;
                n_log++;
            end
            if (tag_en && tag_we) begin
                if (wr_seq >= 2 * NIDX || int'(tag_way) != wr_seq / NIDX || int'(tag_idx) != wr_seq % NIDX)
                    order_err++;
                if (ent_cnt[tag_way][tag_idx] != dirty_cnt(img[tag_way][tag_idx])) early_err++;
                if (tag_wdata != '0) data_err++;
                wr_seq++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_image(input int seed, input bit clean);
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < NIDX; i++) begin
                int k = w * NIDX + i;
                logic v = ((k + seed) % 4) != 0;
                logic [SECTORS-1:0] d = clean ? '0 : SECTORS'((k * 3 + seed) % 4);
                logic [TAG_W-1:0] t = TAG_W'((k * 37 + seed * 11) % 1024);
                img[w][i] = {v, d, t};
                mem[w][i] = {v, d, t};
            end
    endtask

    task automatic cfg_write(input logic v);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_wr_flush = v;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
        chk(!busy, req, busy, 0);
    endtask

    task automatic check_results(input string tag);
        int k = 0;
        bit ok = 1;
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < NIDX; i++)
                if (img[w][i][ENT_W-1])
                    for (int s = 0; s < SECTORS; s++)
                        if (img[w][i][TAG_W + s]) begin
                            int ea = (((int'(img[w][i][TAG_W-1:0]) * NIDX + i) * SECTORS + s) * 32);
                            if (k >= n_log || int'(log_addr[k]) != ea || int'(log_way[k]) != w) ok = 0;
                            k++;
                        end
        chk(ok && k == n_log, {tag, " R4 castout list"}, n_log, k);
        chk(order_err == 0 && wr_seq == 2 * NIDX, {tag, " R3 walk order"}, wr_seq, 2 * NIDX);
        chk(early_err == 0 && data_err == 0, {tag, " R6 invalidate after castouts"}, early_err + data_err, 0);
        chk(hold_err == 0, {tag, " R5 hold under stall"}, hold_err, 0);
        chk(snoop_err == 0, {tag, " R8 snoop yield"}, snoop_err, 0);
        chk(idle_err == 0, {tag, " R7 activity only while busy"}, idle_err, 0);
        ok = 1;
        for (int w = 0; w < 2; w++) for (int i = 0; i < NIDX; i++) if (mem[w][i][ENT_W-1]) ok = 0;
        chk(ok && !cfg_rd_flush, {tag, " R10 all invalid, flag clear"}, cfg_rd_flush, 0);
    endtask

    task automatic run_flush(input int seed, input bit clean, input string tag);
        load_image(seed, clean);
        mon_clear();
        cfg_write(1'b1);
        @(negedge clk);
        chk(busy && cfg_rd_flush, {tag, " R7 busy after start"}, busy, 1);
        wait_done({tag, " R10 completion"});
        check_results(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !cfg_rd_flush && !co_valid && !tag_en, "R1 reset state",
            {busy, cfg_rd_flush, co_valid, tag_en}, 0);
    endtask

    task automatic t_idle_zero();
        mon_clear();
        cfg_write(1'b0);
        @(negedge clk);
        chk(!busy && !cfg_rd_flush, "R2 write 0 while idle", busy, 0);
    endtask

    task automatic t_start_pos();
        load_image(1, 0);
        mon_clear();
        cfg_write(1'b1);
        @(negedge clk);
        chk(tag_en && !tag_we && tag_idx == 0 && !tag_way, "R2 first read way0 idx0",
            {tag_way, tag_idx}, 0);
        wait_done("R2 completion");
        check_results("R2");
    endtask

    task automatic t_writes_midrun();
        load_image(5, 0);
        mon_clear();
        rdy_mode = 1;
        cfg_write(1'b1);
        repeat (10) @(negedge clk);
        cfg_write(1'b0);
        @(negedge clk);
        chk(busy && cfg_rd_flush, "R9 write 0 no abort", busy, 1);
        repeat (8) @(negedge clk);
        cfg_write(1'b1);
        wait_done("R9 completion");
        check_results("R9");
        rdy_mode = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_idle_zero();
        t_start_pos();
        run_flush(2, 0, "plain");
        rdy_mode = 1;
        run_flush(3, 0, "stall");
        rdy_mode = 0; snp_mode = 1;
        run_flush(4, 0, "snoop");
        rdy_mode = 1;
        run_flush(6, 0, "stall+snoop");
        rdy_mode = 0; snp_mode = 0;
        run_flush(7, 1, "clean R6");
        chk(n_log == 0, "R6 clean entries no castout", n_log, 0);
        t_writes_midrun();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule